// File: doc/BRIEF.md
# Directory Update Control Unit

This block is the purely combinational control of the last stage of a directory pipeline. For the message being processed it chooses where the line's current directory metadata comes from. The candidates are the transaction table (transient lines), the tag/state cache (stable lines), the replacement path, or a built-in default for lines the directory does not track.

An external protocol table looks at that current state and returns a next state plus action flags. From the current and next states and those flags, the block derives:
- allocate, deallocate and update strobes for the transaction table, together with its write index;
- allocate, deallocate and update strobes for the directory cache;
- a victim enqueue toward the replacement queue;
- send strobes toward the network interface.

Instruction-fetch misses skip the coherence logic and go directly to memory.

State codes are small integers. Codes 0 to 3 are the stable states: N (not tracked) = 0, I = 1, S = 2 and M = 3. Every code of 4 or above is transient; for example S_D = 4, MN_A = 5, SN_A = 6 and NS_D = 7.

Top module: `dir_update_ctl`

## Requirements
- R1: Current state, sharers and owner come from the transaction table when `tt_hit` is 1; otherwise from the cache when `c_hit` is 1; otherwise from the replacement path when `msg_is_repl` is 1; otherwise from the default.
- R2: The default source gives state code 0 (N), an all-zero sharers vector, and owner equal to parameter `MEM_TILE_ID`.
- R3: A state code is stable when it is below 4 (N=0, I=1, S=2, M=3). Every code of 4 or above is transient.
- R4: For an active message, the transaction table is allocated on a stable→transient move and deallocated on a transient→stable move. It is updated on a transient→transient move only when `pt_info_upd` is 1.
- R5: `tt_wr_index` equals `tt_free_index` when `tt_alloc` is 1, and `tt_index` otherwise.
- R6: For an active message, `c_upd` is 1 when the current and next states are both stable, `c_hit` is 1, and either `pt_info_upd` or `pt_store_data` is 1.
- R7: For an active message, `c_alloc` is 1 when all of the following hold: the next state is stable; `pt_info_upd` or `pt_store_data` is 1; `c_upd` is 0; and it is not the case that a table deallocation coincides with `pt_inval_way`.
- R8: `c_dealloc` is 1 when a table allocation occurs and `c_hit` is 1.
- R9: `rq_enqueue` is 1 when all of the following hold: the message is active; `c_way_valid` is 1; `c_alloc` or `c_upd` is 1; `c_dealloc` is 0; `msg_is_repl` is 0; and `c_hit` is 0.
- R10: For an active message, `net_resp_send` follows `pt_send_resp` and `net_fwd_send` follows `pt_send_fwd`.
- R11: When `msg_valid` is 0, every strobe output is 0 and `tt_wr_index` equals `tt_index`.
- R12: When `msg_valid` and `msg_is_ifetch` are both 1, `mem_bypass_send` is 1 and every coherence strobe is 0. An active message is one with `msg_valid`=1 and `msg_is_ifetch`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| msg_valid | input | 1 | Message present in the stage |
| msg_is_repl | input | 1 | Message is a replacement |
| msg_is_ifetch | input | 1 | Message is an instruction-fetch miss |
| tt_hit | input | 1 | Transaction table holds the line |
| tt_state | input | STATE_W | Table entry state |
| tt_sharers | input | TILES | Table entry sharers |
| tt_owner | input | OWNER_W | Table entry owner |
| tt_index | input | IDX_W | Index found by the earlier lookup |
| tt_free_index | input | IDX_W | First free table index |
| c_hit | input | 1 | Directory cache holds the line |
| c_way_valid | input | 1 | Selected cache way holds a valid line |
| c_state | input | STATE_W | Cache state |
| c_sharers | input | TILES | Cache sharers |
| c_owner | input | OWNER_W | Cache owner |
| rp_state | input | STATE_W | Replacement path state |
| rp_sharers | input | TILES | Replacement path sharers |
| rp_owner | input | OWNER_W | Replacement path owner |
| pt_next_state | input | STATE_W | Next state from protocol table |
| pt_info_upd | input | 1 | Protocol asks for a metadata update |
| pt_store_data | input | 1 | Protocol asks to store data |
| pt_inval_way | input | 1 | Protocol asks to invalidate the way |
| pt_send_resp | input | 1 | Protocol asks for a response message |
| pt_send_fwd | input | 1 | Protocol asks for a forwarded message |
| cur_state | output | STATE_W | Selected current state |
| cur_sharers | output | TILES | Selected current sharers |
| cur_owner | output | OWNER_W | Selected current owner |
| tt_alloc | output | 1 | Allocate table entry |
| tt_dealloc | output | 1 | Free table entry |
| tt_upd | output | 1 | Rewrite table entry |
| tt_wr_index | output | IDX_W | Table entry to write |
| c_alloc | output | 1 | Allocate cache line |
| c_dealloc | output | 1 | Invalidate cache line |
| c_upd | output | 1 | Rewrite cache line |
| rq_enqueue | output | 1 | Push victim into the replacement queue |
| net_resp_send | output | 1 | Send response message |
| net_fwd_send | output | 1 | Send forwarded message |
| mem_bypass_send | output | 1 | Forward instruction-fetch miss to memory |

## Verification
The bench builds the block with 3-bit states, four tiles, a four-entry table and `MEM_TILE_ID` = 3.

With 3-bit states, all eight codes can be swept: the four stable ones and four transient ones. Every current/next pairing is therefore covered. The sweep also crosses all eight source-select combinations of table hit, cache hit and replacement. Each source carries a different state, owner and sharers value, so a wrong priority changes the outputs.

All 32 protocol flag patterns and both way-valid values are applied. The whole sweep is repeated for three message modes: active, not valid, and instruction fetch.

// File: rtl/dir_update_ctl.sv
module dir_update_ctl #(
  parameter int STATE_W     = 3,
  parameter int TILES       = 4,
  parameter int TT_DEPTH    = 4,
  parameter int MEM_TILE_ID = 0
) (
  input  logic                         msg_valid,
  input  logic                         msg_is_repl,
  input  logic                         msg_is_ifetch,
  input  logic                         tt_hit,
  input  logic [STATE_W-1:0]           tt_state,
  input  logic [TILES-1:0]             tt_sharers,
  input  logic [$clog2(TILES)-1:0]     tt_owner,
  input  logic [$clog2(TT_DEPTH)-1:0]  tt_index,
  input  logic [$clog2(TT_DEPTH)-1:0]  tt_free_index,
  input  logic                         c_hit,
  input  logic                         c_way_valid,
  input  logic [STATE_W-1:0]           c_state,
  input  logic [TILES-1:0]             c_sharers,
  input  logic [$clog2(TILES)-1:0]     c_owner,
  input  logic [STATE_W-1:0]           rp_state,
  input  logic [TILES-1:0]             rp_sharers,
  input  logic [$clog2(TILES)-1:0]     rp_owner,
  input  logic [STATE_W-1:0]           pt_next_state,
  input  logic                         pt_info_upd,
  input  logic                         pt_store_data,
  input  logic                         pt_inval_way,
  input  logic                         pt_send_resp,
  input  logic                         pt_send_fwd,
  output logic [STATE_W-1:0]           cur_state,
  output logic [TILES-1:0]             cur_sharers,
  output logic [$clog2(TILES)-1:0]     cur_owner,
  output logic                         tt_alloc,
  output logic                         tt_dealloc,
  output logic                         tt_upd,
  output logic [$clog2(TT_DEPTH)-1:0]  tt_wr_index,
  output logic                         c_alloc,
  output logic                         c_dealloc,
  output logic                         c_upd,
  output logic                         rq_enqueue,
  output logic                         net_resp_send,
  output logic                         net_fwd_send,
  output logic                         mem_bypass_send
);

  localparam int OWNER_W = $clog2(TILES);
  localparam logic [STATE_W-1:0] FIRST_TRANSIENT = STATE_W'(4);
  localparam logic [OWNER_W-1:0] MEM_OWNER = OWNER_W'(MEM_TILE_ID);

  // R1 / R2: metadata source priority
  always_comb begin
    if (tt_hit) begin
      cur_state   = tt_state;
      cur_sharers = tt_sharers;
      cur_owner   = tt_owner;
    end else if (c_hit) begin
      cur_state   = c_state;
      cur_sharers = c_sharers;
      cur_owner   = c_owner;
    end else if (msg_is_repl) begin
      cur_state   = rp_state;
      cur_sharers = rp_sharers;
      cur_owner   = rp_owner;
    end else begin
      cur_state   = '0;
      cur_sharers = '0;
      cur_owner   = MEM_OWNER;
    end
  end

  // R3: stable decode
  logic cur_stable, nxt_stable, active, wants_write;
  assign cur_stable  = cur_state < FIRST_TRANSIENT;
  assign nxt_stable  = pt_next_state < FIRST_TRANSIENT;
  assign active      = msg_valid & ~msg_is_ifetch;
  assign wants_write = pt_info_upd | pt_store_data;

  // R4 / R5: transaction table
  assign tt_alloc    = active &  cur_stable & ~nxt_stable;
  assign tt_dealloc  = active & ~cur_stable &  nxt_stable;
  assign tt_upd      = active & ~cur_stable & ~nxt_stable & pt_info_upd;
  assign tt_wr_index = tt_alloc ? tt_free_index : tt_index;

  // R6..R8: directory cache
  assign c_upd     = active & cur_stable & nxt_stable & c_hit & wants_write;
  assign c_alloc   = active & nxt_stable & wants_write
                   & ~(tt_dealloc & pt_inval_way) & ~c_upd;
  assign c_dealloc = tt_alloc & c_hit;

  // R9: victim enqueue
  assign rq_enqueue = msg_valid & c_way_valid & (c_alloc | c_upd) & ~c_dealloc
                    & ~msg_is_repl & ~c_hit;

  // R10 / R12: messages
  assign net_resp_send   = active & pt_send_resp;
  assign net_fwd_send    = active & pt_send_fwd;
  assign mem_bypass_send = msg_valid & msg_is_ifetch;

  always_comb begin
    a_r4_tt_onehot: assert ($onehot0({tt_alloc, tt_dealloc, tt_upd}))
      else $error("table strobes overlap");
    a_r7_cache_onehot: assert ($onehot0({c_alloc, c_dealloc, c_upd}))
      else $error("cache strobes overlap");
    a_r8_dealloc_hit: assert (!c_dealloc || (c_hit && tt_alloc))
      else $error("cache dealloc without hit and table alloc");
    a_r9_enq_miss: assert (!rq_enqueue || (!c_hit && c_alloc && !msg_is_repl))
      else $error("enqueue on hit or replacement");
    a_r11_idle: assert (msg_valid || !(tt_alloc | tt_dealloc | tt_upd | c_alloc |
                        c_dealloc | c_upd | rq_enqueue | net_resp_send |
                        net_fwd_send | mem_bypass_send))
      else $error("strobe without valid message");
    a_r12_bypass: assert (!mem_bypass_send || !(tt_alloc | tt_dealloc | tt_upd |
                          c_alloc | c_dealloc | c_upd | rq_enqueue |
                          net_resp_send | net_fwd_send))
      else $error("coherence strobe on fetch bypass");
  end

endmodule

// File: tb/dir_update_ctl_test.sv
module dir_update_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 3, T = 4, D = 4, MEM = 3;
  localparam int OW = 2, IW = 2;

  logic clk = 0, rst = 1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic msg_valid, msg_is_repl, msg_is_ifetch, tt_hit, c_hit, c_way_valid;
  logic [SW-1:0] tt_state, c_state, rp_state, pt_next_state, cur_state;
  logic [T-1:0] tt_sharers, c_sharers, rp_sharers, cur_sharers;
  logic [OW-1:0] tt_owner, c_owner, rp_owner, cur_owner;
  logic [IW-1:0] tt_index, tt_free_index, tt_wr_index;
  logic pt_info_upd, pt_store_data, pt_inval_way, pt_send_resp, pt_send_fwd;
  logic tt_alloc, tt_dealloc, tt_upd, c_alloc, c_dealloc, c_upd, rq_enqueue;
  logic net_resp_send, net_fwd_send, mem_bypass_send;

  dir_update_ctl #(.STATE_W(SW), .TILES(T), .TT_DEPTH(D), .MEM_TILE_ID(MEM)) uut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    {msg_valid, msg_is_repl, msg_is_ifetch, tt_hit, c_hit, c_way_valid} = '0;
    {tt_state, c_state, rp_state, pt_next_state} = '0;
    {tt_sharers, c_sharers, rp_sharers} = '0;
    {tt_owner, c_owner, rp_owner} = '0;
    tt_index = 2'd1; tt_free_index = 2'd2;
    {pt_info_upd, pt_store_data, pt_inval_way, pt_send_resp, pt_send_fwd} = '0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 reset state", 32'(cur_state), 0);
    chk("R2 reset owner", 32'(cur_owner), MEM);
    chk("R11 reset strobes", 32'({tt_alloc, tt_dealloc, tt_upd, c_alloc, c_dealloc,
        c_upd, rq_enqueue, net_resp_send, net_fwd_send, mem_bypass_send}), 0);
    chk("R5 reset index", 32'(tt_wr_index), 1);

    tt_sharers = 4'b0001; c_sharers = 4'b0010; rp_sharers = 4'b0100;
    tt_owner = 2'd0; c_owner = 2'd1; rp_owner = 2'd2;
    for (int m = 0; m < 3; m++)
      for (int sel = 0; sel < 8; sel++)
        for (int s = 0; s < 8; s++)
          for (int n = 0; n < 8; n++)
            for (int f = 0; f < 32; f++)
              for (int wv = 0; wv < 2; wv++) begin
                int cs, csh, cow;
                bit th, ch, rp, act, cst, nst, info, st, inv;
                bit ta, td, tu, cu, ca, cd, enq;
                @(posedge clk);
                msg_valid = (m != 1); msg_is_ifetch = (m == 2);
                th = sel[2]; ch = sel[1]; rp = sel[0];
                tt_hit = th; c_hit = ch; msg_is_repl = rp;
                tt_state = SW'(s); c_state = SW'((s + 1) % 8); rp_state = SW'((s + 2) % 8);
                pt_next_state = SW'(n);
                {pt_info_upd, pt_store_data, pt_inval_way, pt_send_resp, pt_send_fwd} = 5'(f);
                c_way_valid = wv[0];
                @(negedge clk);
                // R1/R2 expected source
                if (th) begin cs = s; csh = 1; cow = 0; end
                else if (ch) begin cs = (s + 1) % 8; csh = 2; cow = 1; end
                else if (rp) begin cs = (s + 2) % 8; csh = 4; cow = 2; end
                else begin cs = 0; csh = 0; cow = MEM; end
                info = f[4]; st = f[3]; inv = f[2];
                act = (m == 0);
                cst = cs < 4; nst = n < 4;            // R3
                ta = act & cst & !nst;
                td = act & !cst & nst;
                tu = act & !cst & !nst & info;
                cu = act & cst & nst & ch & (info | st);
                ca = act & nst & (info | st) & !(td & inv) & !cu;
                cd = ta & ch;
                enq = act & wv[0] & (ca | cu) & !cd & !rp & !ch;
                chk("R1 cur_state", 32'(cur_state), cs);
                chk("R1 cur_sharers", 32'(cur_sharers), csh);
                chk("R2 cur_owner", 32'(cur_owner), cow);
                chk("R3/R4 table strobes", 32'({tt_alloc, tt_dealloc, tt_upd}), {ta, td, tu});
                chk("R5 tt_wr_index", 32'(tt_wr_index), ta ? 2 : 1);
                chk("R6 c_upd", 32'(c_upd), cu);
                chk("R7 c_alloc", 32'(c_alloc), ca);
                chk("R8 c_dealloc", 32'(c_dealloc), cd);
                chk("R9 rq_enqueue", 32'(rq_enqueue), enq);
                chk("R10 sends", 32'({net_resp_send, net_fwd_send}), act ? f[1:0] : 0);
                chk("R12 mem_bypass_send", 32'(mem_bypass_send), m == 2);
                if (m == 1)
                  chk("R11 idle strobes", 32'({tt_alloc, tt_dealloc, tt_upd, c_alloc,
                      c_dealloc, c_upd, rq_enqueue, net_resp_send, net_fwd_send}), 0);
              end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule